// File: doc/BRIEF.md
# UART Interrupt Priority and Auto-Sleep Controller

This block gathers the interrupt causes of a UART (receive line errors, receive data at trigger level or character timeout, transmit holding register empty, and a change on the clear-to-send input) and presents them to the host. Only one cause is reported at a time: the highest-ranked pending cause that the host has enabled. That cause is shown as a 4-bit status code, and it drives a level-sensitive interrupt output.

The controller also runs an automatic sleep state that gates the baud oscillator. Sleep starts only under all of these conditions: the host has set the sleep-enable bit, no enabled interrupt is pending, the transmitter has sent its last character, and the receive FIFO has been drained. Once the controller is asleep, it stays asleep until the host clears the sleep-enable bit. New interrupt activity does not end sleep.

Register decode, the FIFOs and the serial datapaths are outside this block. They supply level and pulse indications, and they forward the status-register and modem-status-register read strobes.

Top module: `uart_irq_sleep_ctl`

## Requirements
- R1: The reported cause follows a fixed ranking, from highest to lowest: line error (code 4'b0110), then receive data (code 4'b0100), then transmit empty (code 4'b0010), then modem change (code 4'b0000).
- R2: A receive character timeout reports code 4'b1100 at the receive-data rank. When receive data and timeout are both pending, timeout is reported.
- R3: When no enabled cause is pending, the status code reads 4'b0001 (bit 0 set) and `irq` is low.
- R4: A cause whose enable bit is 0 is neither reported nor drives `irq`. The enable bits are `ien[0]` receive, `ien[1]` transmit empty, `ien[2]` line error and `ien[3]` modem.
- R5: A pulse on `tx_empty_evt` latches a pending transmit-empty cause from the next cycle on. A status read (`isr_rd`) clears it, but only when transmit empty is the cause being reported in that cycle.
- R6: Any change of `cts_in` sets `cts_delta` from the next cycle, and this raises the modem cause. Only `msr_rd` clears it. If a change and a read fall in the same cycle, the change wins.
- R7: `irq` is high exactly when an enabled cause is pending.
- R8: `sleep` rises one cycle after a cycle in which all of these hold: `ien[4]` is 1, `irq` is low, `tx_idle` is 1 and `rx_empty` is 1. It never rises while any of them is false.
- R9: Once `sleep` is high, it stays high while `ien[4]` is 1, even if a cause becomes pending. It falls in the cycle after `ien[4]` reads 0.
- R10: After reset, `cts_delta`, the transmit-empty latch and `sleep` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ien | input | 5 | Enables: [0] rx, [1] tx empty, [2] line, [3] modem, [4] sleep |
| line_err | input | 1 | Receive line error pending (level) |
| rx_ready | input | 1 | Receive data at trigger level (level) |
| rx_timeout | input | 1 | Receive character timeout (level) |
| tx_empty_evt | input | 1 | Transmit holding register became empty (pulse) |
| cts_in | input | 1 | Clear-to-send input |
| isr_rd | input | 1 | Status register read strobe |
| msr_rd | input | 1 | Modem status register read strobe |
| tx_idle | input | 1 | Transmitter has sent its last character |
| rx_empty | input | 1 | Receive FIFO is empty |
| irq | output | 1 | Interrupt request |
| isr_code | output | 4 | Code of the highest-ranked pending cause |
| cts_delta | output | 1 | Clear-to-send changed since the last modem read |
| sleep | output | 1 | Oscillator gate request |

## Verification
The hardest case is a status read that arrives while transmit empty is latched but hidden behind a higher-ranked receive cause. That read must leave the latch alone. The stimulus therefore pulses the transmit event with receive data present, reads the status, then withdraws the receive cause and expects transmit empty to surface. A second hard case is sleep persisting through a new line error. The stimulus reaches it by first driving every entry condition true, then raising the error, and only later clearing the sleep-enable bit.

// File: rtl/uart_irq_sleep_ctl.sv
module uart_irq_sleep_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] ien,
  input  logic       line_err,
  input  logic       rx_ready,
  input  logic       rx_timeout,
  input  logic       tx_empty_evt,
  input  logic       cts_in,
  input  logic       isr_rd,
  input  logic       msr_rd,
  input  logic       tx_idle,
  input  logic       rx_empty,
  output logic       irq,
  output logic [3:0] isr_code,
  output logic       cts_delta,
  output logic       sleep
);

  localparam logic [3:0] CODE_NONE  = 4'b0001;
  localparam logic [3:0] CODE_LINE  = 4'b0110;
  localparam logic [3:0] CODE_RXD   = 4'b0100;
  localparam logic [3:0] CODE_RXTO  = 4'b1100;
  localparam logic [3:0] CODE_TXE   = 4'b0010;
  localparam logic [3:0] CODE_MODEM = 4'b0000;

  logic tx_pend;
  logic cts_prev;

  wire act_line  = ien[2] & line_err;
  wire act_rx    = ien[0] & (rx_ready | rx_timeout);
  wire act_tx    = ien[1] & tx_pend;
  wire act_modem = ien[3] & cts_delta;

  assign irq = act_line | act_rx | act_tx | act_modem;

  always_comb begin
    if (act_line)       isr_code = CODE_LINE;
    else if (act_rx)    isr_code = rx_timeout ? CODE_RXTO : CODE_RXD;
    else if (act_tx)    isr_code = CODE_TXE;
    else if (act_modem) isr_code = CODE_MODEM;
    else                isr_code = CODE_NONE;
  end

  wire tx_ack = isr_rd & (isr_code == CODE_TXE);

  always_ff @(posedge clk) cts_prev <= cts_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_pend   <= 1'b0;
      cts_delta <= 1'b0;
      sleep     <= 1'b0;
    end else begin
      if (tx_empty_evt) tx_pend <= 1'b1;
      else if (tx_ack)  tx_pend <= 1'b0;
      if (cts_in != cts_prev) cts_delta <= 1'b1;
      else if (msr_rd)        cts_delta <= 1'b0;
      sleep <= ien[4] & (sleep | (~irq & tx_idle & rx_empty));
    end
  end

endmodule

// File: rtl/uart_irq_sleep_ctl_chk.sv
module uart_irq_sleep_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] ien,
  input logic       line_err,
  input logic       tx_empty_evt,
  input logic       cts_in,
  input logic       isr_rd,
  input logic       tx_idle,
  input logic       rx_empty,
  input logic       irq,
  input logic [3:0] isr_code,
  input logic       cts_delta,
  input logic       sleep
);

  AST_LINE_ON_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (line_err && ien[2]) |-> (isr_code == 4'b0110)); // R1

  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> (isr_code == 4'b0001)); // R3

  AST_TX_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_rd && isr_code == 4'b0010 && !tx_empty_evt) |=> (isr_code != 4'b0010)); // R5

  AST_CTS_EDGE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && cts_in != $past(cts_in)) |=> cts_delta); // R6

  AST_SLEEP_ENTRY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep) |-> $past(ien[4] && !irq && tx_idle && rx_empty)); // R8

  AST_SLEEP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !ien[4] |=> !sleep); // R9

  AST_SLEEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && ien[4]) |=> sleep); // R9

endmodule

bind uart_irq_sleep_ctl uart_irq_sleep_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ien(ien), .line_err(line_err),
  .tx_empty_evt(tx_empty_evt), .cts_in(cts_in), .isr_rd(isr_rd),
  .tx_idle(tx_idle), .rx_empty(rx_empty), .irq(irq), .isr_code(isr_code),
  .cts_delta(cts_delta), .sleep(sleep)
);

// File: tb/tb_uart_irq_sleep_ctl.sv
module tb_uart_irq_sleep_ctl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] ien = '0;
  logic line_err = 0, rx_ready = 0, rx_timeout = 0, tx_empty_evt = 0;
  logic cts_in = 1, isr_rd = 0, msr_rd = 0, tx_idle = 0, rx_empty = 0;
  logic irq, cts_delta, sleep;
  logic [3:0] isr_code;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct {
    logic [3:0] code;
    logic       irq;
    logic       delta;
    logic       slp;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_sleep_ctl dut (
    .clk(clk), .rst_n(rst_n), .ien(ien), .line_err(line_err),
    .rx_ready(rx_ready), .rx_timeout(rx_timeout), .tx_empty_evt(tx_empty_evt),
    .cts_in(cts_in), .isr_rd(isr_rd), .msr_rd(msr_rd), .tx_idle(tx_idle),
    .rx_empty(rx_empty), .irq(irq), .isr_code(isr_code),
    .cts_delta(cts_delta), .sleep(sleep)
  );

  task automatic expect_now(input logic [3:0] c, input logic i, input logic d,
                            input logic s, input string tag);
    exp_t e;
    e.code = c; e.irq = i; e.delta = d; e.slp = s; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic step(input logic [3:0] c, input logic i, input logic d,
                      input logic s, input string tag);
    @(posedge clk);
    #1;
    expect_now(c, i, d, s, tag);
    @(negedge clk);
  endtask

  initial begin
    forever begin
      exp_t e;
      wait (sb.size() > 0);
      e = sb.pop_front();
      n_checks++;
      if (isr_code !== e.code || irq !== e.irq || cts_delta !== e.delta || sleep !== e.slp) begin
        n_fail++;
        $display("FAIL %s: got code=%b irq=%b delta=%b sleep=%b, expected code=%b irq=%b delta=%b sleep=%b",
                 e.tag, isr_code, irq, cts_delta, sleep, e.code, e.irq, e.delta, e.slp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 expect_now(4'b0001, 0, 0, 0, "R10 reset state");
    @(negedge clk);
    rst_n = 1'b1;
    step(4'b0001, 0, 0, 0, "R10 after release");

    ien = 5'b01111; line_err = 1; rx_ready = 1;
    step(4'b0110, 1, 0, 0, "R1 line over rx");
    line_err = 0;
    step(4'b0100, 1, 0, 0, "R1 rx data");
    rx_timeout = 1;
    step(4'b1100, 1, 0, 0, "R2 timeout with data");
    rx_ready = 0;
    step(4'b1100, 1, 0, 0, "R2 timeout alone");
    rx_timeout = 0; tx_empty_evt = 1;
    step(4'b0010, 1, 0, 0, "R5 tx latched");
    tx_empty_evt = 0; isr_rd = 1;
    step(4'b0001, 0, 0, 0, "R5 read clears tx / R3 idle");
    isr_rd = 0; tx_empty_evt = 1; rx_ready = 1;
    step(4'b0100, 1, 0, 0, "R1 rx over tx");
    tx_empty_evt = 0; isr_rd = 1;
    step(4'b0100, 1, 0, 0, "R5 read with rx shown");
    isr_rd = 0; rx_ready = 0;
    step(4'b0010, 1, 0, 0, "R5 hidden tx survives read");
    isr_rd = 1;
    step(4'b0001, 0, 0, 0, "R5 tx cleared");
    isr_rd = 0; cts_in = 0;
    step(4'b0000, 1, 1, 0, "R6 cts change");
    isr_rd = 1;
    step(4'b0000, 1, 1, 0, "R6 status read keeps modem");
    isr_rd = 0; msr_rd = 1;
    step(4'b0001, 0, 0, 0, "R6 modem read clears");
    msr_rd = 0; cts_in = 1;
    step(4'b0000, 1, 1, 0, "R6 cts rising");
    ien = 5'b00111;
    step(4'b0001, 0, 1, 0, "R4 modem masked");
    msr_rd = 1;
    step(4'b0001, 0, 0, 0, "R6 clear");
    msr_rd = 0; ien = 5'b00000; line_err = 1; rx_ready = 1;
    step(4'b0001, 0, 0, 0, "R4 all masked / R7");
    line_err = 0; rx_ready = 0;

    ien = 5'b10000; tx_idle = 1; rx_empty = 1;
    step(4'b0001, 0, 0, 1, "R8 sleep entry");
    ien = 5'b00000;
    step(4'b0001, 0, 0, 0, "R9 sleep release");
    ien = 5'b10100; line_err = 1;
    step(4'b0110, 1, 0, 0, "R8 blocked by irq");
    line_err = 0; tx_idle = 0;
    step(4'b0001, 0, 0, 0, "R8 blocked by tx busy");
    tx_idle = 1; rx_empty = 0;
    step(4'b0001, 0, 0, 0, "R8 blocked by rx data");
    rx_empty = 1;
    step(4'b0001, 0, 0, 1, "R8 sleep entry all quiet");
    line_err = 1;
    step(4'b0110, 1, 0, 1, "R9 sleep holds with irq");
    ien = 5'b00100;
    step(4'b0110, 1, 0, 0, "R9 cleared by enable bit");

    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule